// File: doc/BRIEF.md
# Fence ordering set adjuster

This block sits in front of a memory-ordering unit. Each cycle it looks at one 32-bit instruction word and decides whether the word is a plain memory fence. If it is, the block produces the fence's effective predecessor and successor ordering sets, plus a compact code naming the class of ordering between ordinary memory reads and writes. All outputs are registered, so results appear one cycle after the inputs.

The block supports a mode in which device accesses are also treated as ordinary memory accesses. When this mode is active for the current privilege level, a device-input bit in a set also sets the memory-read bit, and a device-output bit also sets the memory-write bit. Two configuration bits control the mode: one owned by machine level and one owned by supervisor level. The current privilege level decides which of the two bits apply. The ordering unit downstream only has to act on the adjusted sets or on the class code.

Top module: `fence_set_adjust`

## Requirements
- R1: A word is recognized as a fence only when bits 31..28 are 0000, bits 19..7 are all zero and bits 6..0 equal 0001111; any other word is rejected.
- R2: The predecessor set is taken from bits 27..24 and the successor set from bits 23..20. In each set, bit 3 is device input (I), bit 2 is device output (O), bit 1 is memory read (R) and bit 0 is memory write (W).
- R3: While the mode is active, each set's R bit becomes R OR I and its W bit becomes W OR O; the I and O bits pass through unchanged. The adjustment is applied to each set on its own, with no mixing between the two sets.
- R4: With privilege code 11 (machine), the mode is never active. The unused code 10 is treated the same way. Both sets pass through unchanged.
- R5: With privilege code 01 (supervisor), the mode is active exactly when the machine-level bit is 1; the supervisor-level bit has no effect.
- R6: With privilege code 00 (user), the mode is active when either the machine-level bit or the supervisor-level bit is 1.
- R7: The class code is computed from p and s, the 2-bit {R,W} fields of the adjusted predecessor and successor sets. It is 0 (no-op) when p or s is 0. Otherwise it is 3*(p-1)+s, which gives values from 1 to 9.
- R8: For a rejected word, the valid flag is 0 and both sets and the class code are 0.
- R9: All outputs change one clock after their inputs. While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word to examine |
| priv_i | input | 2 | Current privilege: 11 machine, 01 supervisor, 00 user, 10 unused |
| m_fiom_i | input | 1 | Machine-level enable for treating device accesses as memory |
| s_fiom_i | input | 1 | Supervisor-level enable for treating device accesses as memory |
| valid_o | output | 1 | Registered: previous word was a recognized fence |
| pred_o | output | 4 | Registered adjusted predecessor set (I,O,R,W) |
| succ_o | output | 4 | Registered adjusted successor set (I,O,R,W) |
| class_o | output | 4 | Registered ordering-class code |

## Verification
Field checking and set adjustment both act in the same cycle. The bench provokes this by presenting words that carry device bits and have one bad fixed bit, while the mode is active in user privilege. Rejection must win: such a word must give all-zero outputs, even though its sets would otherwise be widened. The bench also changes privilege and both configuration bits on consecutive cycles while the instruction stays the same. Each result is judged against the inputs of the cycle before it, which exposes any mixing between the mode decision and the adjustment of neighbouring words.

// File: rtl/fence_adj_pkg.sv
package fence_adj_pkg;

    localparam int INSTR_W = 32;
    localparam int SET_W   = 4;
    localparam int CLASS_W = 4;
    localparam int NUM_SETS = 2;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef struct packed {
        logic               valid;
        logic [SET_W-1:0]   pred;
        logic [SET_W-1:0]   succ;
        logic [CLASS_W-1:0] cls;
    } fence_out_t;

endpackage

// File: rtl/fence_field_decode.sv
module fence_field_decode
    import fence_adj_pkg::*;
#(
    parameter logic [6:0] OPCODE = 7'b0001111
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic [SET_W-1:0]   pred,
    output logic [SET_W-1:0]   succ
);
    logic top_ok;
    logic mid_ok;
    logic op_ok;

    always_comb begin
        top_ok = (instr[31:28] == 4'b0000);
        mid_ok = (instr[19:7] == 13'd0);
        op_ok  = (instr[6:0] == OPCODE);
        hit    = top_ok && mid_ok && op_ok;
        pred   = instr[27:24];
        succ   = instr[23:20];
    end
endmodule

// File: rtl/fiom_gate.sv
module fiom_gate
    import fence_adj_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       m_bit,
    input  logic       s_bit,
    output logic       active
);
    always_comb begin
        unique case (priv)
            PRIV_SUPER: active = m_bit;
            PRIV_USER:  active = m_bit | s_bit;
            default:    active = 1'b0;
        endcase
    end
endmodule

// File: rtl/io_set_fold.sv
module io_set_fold #(
    parameter int W = 4
) (
    input  logic [W-1:0] set_in,
    input  logic         active,
    output logic [W-1:0] set_out
);
    localparam int HALF = W / 2;

    always_comb begin
        set_out[W-1:HALF] = set_in[W-1:HALF];
        set_out[HALF-1:0] = active ? (set_in[HALF-1:0] | set_in[W-1:HALF])
                                   : set_in[HALF-1:0];
    end
endmodule

// File: rtl/order_class_enc.sv
module order_class_enc
    import fence_adj_pkg::*;
(
    input  logic [1:0]         pred_rw,
    input  logic [1:0]         succ_rw,
    output logic [CLASS_W-1:0] cls
);
    logic [CLASS_W-1:0] p_ext;
    logic [CLASS_W-1:0] s_ext;

    always_comb begin
        p_ext = {{(CLASS_W-2){1'b0}}, pred_rw};
        s_ext = {{(CLASS_W-2){1'b0}}, succ_rw};
        if (pred_rw == 2'b00 || succ_rw == 2'b00)
            cls = '0;
        else
            cls = (p_ext - 1'b1) * CLASS_W'(3) + s_ext;
    end
endmodule

// File: rtl/fence_set_adjust.sv
module fence_set_adjust
    import fence_adj_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [1:0]         priv_i,
    input  logic               m_fiom_i,
    input  logic               s_fiom_i,
    output logic               valid_o,
    output logic [SET_W-1:0]   pred_o,
    output logic [SET_W-1:0]   succ_o,
    output logic [CLASS_W-1:0] class_o
);
    logic                            hit;
    logic                            fold_on;
    logic [NUM_SETS-1:0][SET_W-1:0]  raw_sets;
    logic [NUM_SETS-1:0][SET_W-1:0]  adj_sets;
    logic [CLASS_W-1:0]              cls;
    fence_out_t                      out_d;
    fence_out_t                      out_q;

    fence_field_decode u_decode (
        .instr (instr_i),
        .hit   (hit),
        .pred  (raw_sets[0]),
        .succ  (raw_sets[1])
    );

    fiom_gate u_gate (
        .priv   (priv_i),
        .m_bit  (m_fiom_i),
        .s_bit  (s_fiom_i),
        .active (fold_on)
    );

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_fold
        io_set_fold #(.W(SET_W)) u_fold (
            .set_in  (raw_sets[g]),
            .active  (fold_on),
            .set_out (adj_sets[g])
        );
    end

    order_class_enc u_enc (
        .pred_rw (adj_sets[0][1:0]),
        .succ_rw (adj_sets[1][1:0]),
        .cls     (cls)
    );

    always_comb begin
        out_d = '0;
        if (hit) begin
            out_d.valid = 1'b1;
            out_d.pred  = adj_sets[0];
            out_d.succ  = adj_sets[1];
            out_d.cls   = cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign valid_o = out_q.valid;
    assign pred_o  = out_q.pred;
    assign succ_o  = out_q.succ;
    assign class_o = out_q.cls;
endmodule

// File: rtl/fence_set_adjust_chk.sv
module fence_set_adjust_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [1:0]  priv_i,
    input logic        m_fiom_i,
    input logic        s_fiom_i,
    input logic        valid_o,
    input logic [3:0]  pred_o,
    input logic [3:0]  succ_o,
    input logic [3:0]  class_o
);
    // R8
    reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (pred_o == 4'd0 && succ_o == 4'd0 && class_o == 4'd0));

    // R3
    io_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (pred_o[3:2] == $past(instr_i[27:26]) &&
                     succ_o[3:2] == $past(instr_i[23:22])));

    // R3
    rw_superset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((pred_o[1:0] & $past(instr_i[25:24])) == $past(instr_i[25:24]) &&
                     (succ_o[1:0] & $past(instr_i[21:20])) == $past(instr_i[21:20])));

    // R4
    mach_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(priv_i) == 2'b11) |->
            (pred_o == $past(instr_i[27:24]) && succ_o == $past(instr_i[23:20])));

    // R6
    user_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(priv_i) == 2'b00 && !$past(m_fiom_i) && !$past(s_fiom_i)) |->
            (pred_o == $past(instr_i[27:24]) && succ_o == $past(instr_i[23:20])));

    // R7
    class_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && (pred_o[1:0] == 2'b00 || succ_o[1:0] == 2'b00)) |-> (class_o == 4'd0));

    // R7
    class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && pred_o[1:0] != 2'b00 && succ_o[1:0] != 2'b00) |->
            (class_o >= 4'd1 && class_o <= 4'd9));
endmodule

bind fence_set_adjust fence_set_adjust_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_i  (instr_i),
    .priv_i   (priv_i),
    .m_fiom_i (m_fiom_i),
    .s_fiom_i (s_fiom_i),
    .valid_o  (valid_o),
    .pred_o   (pred_o),
    .succ_o   (succ_o),
    .class_o  (class_o)
);

// File: tb/fence_set_adjust_tb_top.sv
`timescale 1ns/1ps
module fence_set_adjust_tb_top;

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  pred;
        logic [3:0]  succ;
        logic [1:0]  priv;
        logic        mf;
        logic        sf;
        logic [31:0] bad;
        logic        ev;
        logic [3:0]  ep;
        logic [3:0]  es;
        logic [3:0]  ec;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd4, 4'b1000, 4'b0100, 2'b11, 1'b1, 1'b1, 32'h0, 1'b1, 4'b1000, 4'b0100, 4'd0}, // R4
        '{4'd5, 4'b1000, 4'b0100, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, 4'b1010, 4'b0101, 4'd4}, // R5
        '{4'd5, 4'b1000, 4'b0100, 2'b01, 1'b0, 1'b1, 32'h0, 1'b1, 4'b1000, 4'b0100, 4'd0}, // R5
        '{4'd6, 4'b1000, 4'b0100, 2'b00, 1'b0, 1'b1, 32'h0, 1'b1, 4'b1010, 4'b0101, 4'd4}, // R6
        '{4'd6, 4'b1000, 4'b0100, 2'b00, 1'b0, 1'b0, 32'h0, 1'b1, 4'b1000, 4'b0100, 4'd0}, // R6
        '{4'd7, 4'b0011, 4'b0011, 2'b11, 1'b0, 1'b0, 32'h0, 1'b1, 4'b0011, 4'b0011, 4'd9}, // R7
        '{4'd3, 4'b1100, 4'b0010, 2'b00, 1'b1, 1'b0, 32'h0, 1'b1, 4'b1111, 4'b0010, 4'd8}, // R3
        '{4'd2, 4'b0001, 4'b1000, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, 4'b0001, 4'b1010, 4'd2}, // R2
        '{4'd1, 4'b1111, 4'b1111, 2'b00, 1'b1, 1'b1, 32'h1000_0000, 1'b0, 4'd0, 4'd0, 4'd0}, // R1
        '{4'd1, 4'b1100, 4'b1100, 2'b00, 1'b1, 1'b1, 32'h0000_0080, 1'b0, 4'd0, 4'd0, 4'd0}, // R1
        '{4'd1, 4'b0011, 4'b0011, 2'b11, 1'b0, 1'b0, 32'h0008_0000, 1'b0, 4'd0, 4'd0, 4'd0}, // R1
        '{4'd8, 4'b0011, 4'b0011, 2'b11, 1'b0, 1'b0, 32'h0000_0001, 1'b0, 4'd0, 4'd0, 4'd0}, // R8
        '{4'd4, 4'b1000, 4'b0100, 2'b10, 1'b1, 1'b1, 32'h0, 1'b1, 4'b1000, 4'b0100, 4'd0}, // R4
        '{4'd7, 4'b0000, 4'b0000, 2'b00, 1'b1, 1'b1, 32'h0, 1'b1, 4'b0000, 4'b0000, 4'd0}, // R7
        '{4'd3, 4'b0110, 4'b1001, 2'b01, 1'b1, 1'b0, 32'h0, 1'b1, 4'b0111, 4'b1011, 4'd9}, // R3
        '{4'd6, 4'b0100, 4'b0100, 2'b00, 1'b0, 1'b1, 32'h0, 1'b1, 4'b0101, 4'b0101, 4'd1}  // R6
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr_i;
    logic [1:0]  priv_i;
    logic        m_fiom_i;
    logic        s_fiom_i;
    logic        valid_o;
    logic [3:0]  pred_o;
    logic [3:0]  succ_o;
    logic [3:0]  class_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fence_set_adjust dut_i (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .priv_i(priv_i),
        .m_fiom_i(m_fiom_i), .s_fiom_i(s_fiom_i), .valid_o(valid_o),
        .pred_o(pred_o), .succ_o(succ_o), .class_o(class_o)
    );

    function automatic logic [31:0] mk(input logic [3:0] p, input logic [3:0] s);
        return {4'b0000, p, s, 13'd0, 7'b0001111};
    endfunction

    task automatic check(input string tag, input logic ev, input logic [3:0] ep,
                         input logic [3:0] es, input logic [3:0] ec);
        checks++;
        if ({valid_o, pred_o, succ_o, class_o} !== {ev, ep, es, ec}) begin
            errors++;
            $display("FAIL %s: actual v=%0b p=%4b s=%4b c=%0d expected v=%0b p=%4b s=%4b c=%0d",
                     tag, valid_o, pred_o, succ_o, class_o, ev, ep, es, ec);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic [1:0] pv,
                         input logic mf, input logic sf);
        instr_i = w; priv_i = pv; m_fiom_i = mf; s_fiom_i = sf;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(mk(4'b1111, 4'b1111), 2'b00, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 reset", 1'b0, 4'd0, 4'd0, 4'd0);
        rst_n = 1'b1;

        // table walk: drive at negedge, result visible at next negedge
        for (int i = 0; i < NV; i++) begin
            drive(mk(VECS[i].pred, VECS[i].succ) ^ VECS[i].bad,
                  VECS[i].priv, VECS[i].mf, VECS[i].sf);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].req, i),
                  VECS[i].ev, VECS[i].ep, VECS[i].es, VECS[i].ec);
        end

        // R9: latency; output still shows old word until the next edge
        drive(mk(4'b0011, 4'b0011), 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        drive(mk(4'b1000, 4'b1000), 2'b00, 1'b1, 1'b0);
        #1 check("R9 hold", 1'b1, 4'b0011, 4'b0011, 4'd9);
        @(negedge clk);
        check("R9 next", 1'b1, 4'b1010, 4'b1010, 4'd5);

        // R1 with fold active: rejection beats adjustment
        drive(mk(4'b1100, 4'b1100) | 32'h0000_0800, 2'b00, 1'b1, 1'b1);
        @(negedge clk);
        check("R1 reject under fold", 1'b0, 4'd0, 4'd0, 4'd0);

        // R5: supervisor bit alone in supervisor privilege has no effect
        drive(mk(4'b1100, 4'b0100), 2'b01, 1'b0, 1'b1);
        @(negedge clk);
        check("R5 s bit ignored", 1'b1, 4'b1100, 4'b0100, 4'd0);

        // R9: reset in the middle clears the outputs
        drive(mk(4'b0011, 4'b0011), 2'b11, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset", 1'b0, 4'd0, 4'd0, 4'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after reset", 1'b1, 4'b0011, 4'b0011, 4'd9);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule